// File: doc/BRIEF.md
# DMA channel mode and status register bank

This block is the control and status register bank of a multi-channel DMA controller with up to twelve channels. Software programs each channel's transfer mode and direction, and its interrupt enable, through a 32-bit word-addressed read/write port. The channel engines, which are outside this block, read the programmed mode and direction from dedicated outputs. They report their live 2-bit activity state continuously and raise one-cycle pulses when a transfer completes or fails.

The bank holds a completion flag and an error flag for every channel. A pulse from an engine sets the matching flag, and software clears a flag by writing a 1 to its bit. The bank folds every flag whose channel is enabled into a single registered interrupt line. Channels 0 to 7 occupy the lower control and status words, and channels 8 to 11 occupy a second pair. A driver can therefore clear all pending flags by writing back the status word it has just read.

Top module: `dma_csr_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, every channel mode reads 0 (off), every direction bit, interrupt enable and flag is 0, and both `irq` and `rdata` are 0.
- R2: Word offset 0x00 packs channels 0 to 7 as 4-bit nibbles, channel n at bits [4n+3:4n]. Within a nibble, bits [1:0] are the mode (0 off, 1 descriptor chain, 2 single transfer) and bit 2 is the direction (1 = memory to device). Bit 3 reads 0. A write reaches `ch_mode` and `ch_dir` at the next clock edge.
- R3: Word offset 0x0C packs channels 8 to 11 the same way, channel 8 in bits [3:0] and channel 11 in bits [15:12]. Bits [31:16] read 0.
- R4: A mode code of 3 written to any nibble is stored and read back as 0 (off).
- R5: Word offset 0x08 holds the interrupt enables: bit n for channels 0 to 7, and bit n+8 for channels 8 to 11 (bits 16 to 19). All other bits read 0.
- R6: A read of offset 0x10 returns the live state of channel n (0 idle, 1 descriptor fetch, 2 waiting, 3 moving data) in bits [17+2n:16+2n]. A read of offset 0x18 returns channel n (n = 8 to 11) in bits [17+2(n-8):16+2(n-8)]. The state is sampled at the clock edge of the read.
- R7: A `ch_done` pulse sets the completion flag and a `ch_err` pulse sets the error flag. Channel n below 8 shows them at offset 0x10 in bit n and bit n+8. Channel n from 8 up shows them at offset 0x18 in bit n-8 and bit n.
- R8: Writing 1 to a flag bit clears that flag and writing 0 leaves it unchanged. Writing back a value just read therefore clears exactly the flags that were set.
- R9: A flag that is pulsed in the same cycle as a write that clears it remains set.
- R10: `irq` is high exactly when some channel has its enable set together with its completion or error flag. It changes at the same clock edge as the flags and enables that cause the change.
- R11: Offsets 0x04, 0x14, 0x1C and every offset from 0x20 upward read 0. Writes to them change no state.
- R12: `rdata` takes the addressed word at the clock edge where `rd_en` is high, using the values held before any write in that cycle. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; `rdata` updates at this edge |
| addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch_state | input | 2*NUM_CH | Live activity state, 2 bits per channel |
| ch_done | input | NUM_CH | Completion pulse per channel |
| ch_err | input | NUM_CH | Error pulse per channel |
| ch_mode | output | 2*NUM_CH | Programmed mode, 2 bits per channel |
| ch_dir | output | NUM_CH | Programmed direction per channel |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench aims at the packing boundaries. Channel 8 must land in nibble 0 of the upper control word and its enable at bit 16; a design that carried the lower-bank bit positions upward would misplace both, and the readback and `ch_mode` would differ from the model. Addresses from 0x20 up, such as 0x20 and 0x30, share their low bits with live registers. A design that decoded only the low address bits would let those writes overwrite controls or clear flags. Writes that carry a done pulse and a clear in the same cycle catch a design where the clear wins and drops the event. All-ones writes catch a mode code of 3 stored as is, and a write-back of the status word catches a design that clears flags that were not set or misses ones that were.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned MAX_CH     = 12;
  localparam int unsigned LANE_CH    = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned NIB_USED   = 3;
  localparam int unsigned STATE_W    = 2;
  localparam int unsigned STATE_BASE = 16;
  localparam int unsigned ERR_OFS    = 8;
  localparam int unsigned HI_IEN_OFS = 8;
  localparam int unsigned GLOB_AW    = 5;

  typedef enum logic [1:0] {
    XFER_OFF    = 2'd0,
    XFER_CHAIN  = 2'd1,
    XFER_SINGLE = 2'd2,
    XFER_RSVD   = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    W_CTL_LO  = 3'd0,
    W_CTL_AUX = 3'd1,
    W_IEN     = 3'd2,
    W_CTL_HI  = 3'd3,
    W_STS_LO  = 3'd4,
    W_STS_AUX = 3'd5,
    W_STS_HI  = 3'd6,
    W_GAP     = 3'd7
  } gword_e;

endpackage

// File: rtl/dma_csr_slice.sv
module dma_csr_slice
  import dma_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_we,
  input  logic [NIB_USED-1:0] ctl_nib,
  input  logic                ien_we,
  input  logic                ien_bit,
  input  logic                clr_we,
  input  logic                clr_done,
  input  logic                clr_err,
  input  logic                done_pulse,
  input  logic                err_pulse,
  output xfer_mode_e          mode,
  output logic                dir,
  output logic                ien,
  output logic                done_flag,
  output logic                err_flag,
  output logic                req_nxt
);

  xfer_mode_e mode_d;
  xfer_mode_e nib_mode;
  logic       dir_d, ien_d, done_d, err_d;

  assign nib_mode = xfer_mode_e'(ctl_nib[1:0]);

  always_comb begin
    mode_d = mode;
    dir_d  = dir;
    if (ctl_we) begin
      mode_d = (nib_mode == XFER_RSVD) ? XFER_OFF : nib_mode;
      dir_d  = ctl_nib[2];
    end
    ien_d   = ien_we ? ien_bit : ien;
    done_d  = (done_flag & ~(clr_we & clr_done)) | done_pulse;
    err_d   = (err_flag  & ~(clr_we & clr_err))  | err_pulse;
    req_nxt = ien_d & (done_d | err_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= XFER_OFF;
      dir       <= 1'b0;
      ien       <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      mode      <= mode_d;
      dir       <= dir_d;
      ien       <= ien_d;
      done_flag <= done_d;
      err_flag  <= err_d;
    end
  end

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
  import dma_csr_pkg::*;
(
  input  logic                       in_glob,
  input  gword_e                     gsel,
  input  logic [STATE_W*MAX_CH-1:0]  mode_v,
  input  logic [MAX_CH-1:0]          dir_v,
  input  logic [MAX_CH-1:0]          ien_v,
  input  logic [MAX_CH-1:0]          done_v,
  input  logic [MAX_CH-1:0]          err_v,
  input  logic [STATE_W*MAX_CH-1:0]  state_v,
  output logic [REG_W-1:0]           word
);

  always_comb begin
    word = '0;
    if (in_glob) begin
      case (gsel)
        W_CTL_LO: begin
          for (int c = 0; c < LANE_CH; c++) begin
            word[NIB_W*c +: 2] = mode_v[STATE_W*c +: 2];
            word[NIB_W*c + 2]  = dir_v[c];
          end
        end
        W_CTL_HI: begin
          for (int c = LANE_CH; c < MAX_CH; c++) begin
            word[NIB_W*(c-LANE_CH) +: 2] = mode_v[STATE_W*c +: 2];
            word[NIB_W*(c-LANE_CH) + 2]  = dir_v[c];
          end
        end
        W_IEN: begin
          for (int c = 0; c < MAX_CH; c++) begin
            if (c < LANE_CH) word[c] = ien_v[c];
            else             word[c + HI_IEN_OFS] = ien_v[c];
          end
        end
        W_STS_LO: begin
          for (int c = 0; c < LANE_CH; c++) begin
            word[c]                              = done_v[c];
            word[c + ERR_OFS]                    = err_v[c];
            word[STATE_BASE + STATE_W*c +: 2]    = state_v[STATE_W*c +: 2];
          end
        end
        W_STS_HI: begin
          for (int c = LANE_CH; c < MAX_CH; c++) begin
            word[c-LANE_CH]                             = done_v[c];
            word[c-LANE_CH + ERR_OFS]                   = err_v[c];
            word[STATE_BASE + STATE_W*(c-LANE_CH) +: 2] = state_v[STATE_W*c +: 2];
          end
        end
        default: word = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  input  logic [2*NUM_CH-1:0]   ch_state,
  input  logic [NUM_CH-1:0]     ch_done,
  input  logic [NUM_CH-1:0]     ch_err,
  output logic [2*NUM_CH-1:0]   ch_mode,
  output logic [NUM_CH-1:0]     ch_dir,
  output logic                  irq
);

  logic                         in_glob;
  gword_e                       gsel;
  logic                         wr_glob;
  logic [STATE_W*MAX_CH-1:0]    mode_v;
  logic [STATE_W*MAX_CH-1:0]    state_v;
  logic [MAX_CH-1:0]            dir_v, ien_v, done_v, err_v, req_v;
  logic [REG_W-1:0]             rd_word;
  logic                         unused_ok;

  assign unused_ok = ^{addr[1:0], wdata};
  assign in_glob   = (addr[ADDR_W-1:GLOB_AW] == '0);
  assign gsel      = gword_e'(addr[GLOB_AW-1:2]);
  assign wr_glob   = wr_en & in_glob;

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    localparam int unsigned K  = c % LANE_CH;
    localparam bit          UP = (c >= LANE_CH);
    if (c < NUM_CH) begin : g_live
      xfer_mode_e mode_s;
      logic       ctl_we, clr_we;
      assign ctl_we = wr_glob && (gsel == (UP ? W_CTL_HI : W_CTL_LO));
      assign clr_we = wr_glob && (gsel == (UP ? W_STS_HI : W_STS_LO));
      dma_csr_slice u_slice (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_nib    (wdata[NIB_W*K +: NIB_USED]),
        .ien_we     (wr_glob && (gsel == W_IEN)),
        .ien_bit    (wdata[UP ? c + HI_IEN_OFS : c]),
        .clr_we     (clr_we),
        .clr_done   (wdata[K]),
        .clr_err    (wdata[K + ERR_OFS]),
        .done_pulse (ch_done[c]),
        .err_pulse  (ch_err[c]),
        .mode       (mode_s),
        .dir        (dir_v[c]),
        .ien        (ien_v[c]),
        .done_flag  (done_v[c]),
        .err_flag   (err_v[c]),
        .req_nxt    (req_v[c])
      );
      assign mode_v[STATE_W*c +: 2]  = mode_s;
      assign state_v[STATE_W*c +: 2] = ch_state[STATE_W*c +: 2];
      assign ch_mode[STATE_W*c +: 2] = mode_s;
      assign ch_dir[c]               = dir_v[c];
    end else begin : g_absent
      assign mode_v[STATE_W*c +: 2]  = '0;
      assign state_v[STATE_W*c +: 2] = '0;
      assign dir_v[c]  = 1'b0;
      assign ien_v[c]  = 1'b0;
      assign done_v[c] = 1'b0;
      assign err_v[c]  = 1'b0;
      assign req_v[c]  = 1'b0;
    end
  end

  dma_csr_rdmux u_rdmux (
    .in_glob (in_glob),
    .gsel    (gsel),
    .mode_v  (mode_v),
    .dir_v   (dir_v),
    .ien_v   (ien_v),
    .done_v  (done_v),
    .err_v   (err_v),
    .state_v (state_v),
    .word    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_word;
      irq <= |req_v;
    end
  end

endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [REG_W-1:0]    wdata,
  input logic [REG_W-1:0]    rdata,
  input logic [2*NUM_CH-1:0] ch_state,
  input logic [NUM_CH-1:0]   ch_done,
  input logic [NUM_CH-1:0]   ch_err,
  input logic [2*NUM_CH-1:0] ch_mode,
  input logic [NUM_CH-1:0]   ch_dir,
  input logic                irq,
  input logic [MAX_CH-1:0]   ien_v,
  input logic [MAX_CH-1:0]   done_v,
  input logic [MAX_CH-1:0]   err_v
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == 1'b0 && rdata == '0 && ch_mode == '0 && ch_dir == '0));

  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == |(ien_v & (done_v | err_v)));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  a_r6_state_sample: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(16)) |=> rdata[STATE_BASE +: 2] == $past(ch_state[1:0]));

  a_r11_gap_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr[ADDR_W-1:2] == '1 || addr[ADDR_W-1:2] == (ADDR_W-2)'(7)))
      |=> ($stable(ch_mode) && $stable(ch_dir) && $stable(ien_v)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ck
    localparam int unsigned K  = c % LANE_CH;
    localparam int unsigned SA = (c >= LANE_CH) ? 24 : 16;

    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
      ch_done[c] |=> done_v[c]);

    a_r7_err_sets: assert property (@(posedge clk) disable iff (rst)
      ch_err[c] |=> err_v[c]);

    a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(SA) && wdata[K] && !ch_done[c]) |=> !done_v[c]);

    a_r4_no_rsvd_mode: assert property (@(posedge clk) disable iff (rst)
      ch_mode[2*c +: 2] != 2'b11);
  end

endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .ch_state (ch_state),
  .ch_done  (ch_done),
  .ch_err   (ch_err),
  .ch_mode  (ch_mode),
  .ch_dir   (ch_dir),
  .irq      (irq),
  .ien_v    (ien_v),
  .done_v   (done_v),
  .err_v    (err_v)
);

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;

  localparam int NCH = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [2*NCH-1:0]  st = '0;
  logic [NCH-1:0]    ch_done = '0, ch_err = '0;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir;
  logic              irq;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_csr_bank #(.NUM_CH(NCH), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_state(st), .ch_done(ch_done),
    .ch_err(ch_err), .ch_mode(ch_mode), .ch_dir(ch_dir), .irq(irq)
  );

  // behavioural reference
  logic [1:0]     m_mode [NCH];
  logic [NCH-1:0] m_dir, m_ien, m_done, m_err;
  logic [31:0]    m_rdata;
  logic           m_irq;

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] w;
    w = '0;
    if (a < 8'h20) begin
      case (a[4:2])
        3'd0: for (int c = 0; c < 8; c++) w[4*c +: 3] = {m_dir[c], m_mode[c]};
        3'd3: for (int c = 0; c < 4; c++) w[4*c +: 3] = {m_dir[c+8], m_mode[c+8]};
        3'd2: begin w[7:0] = m_ien[7:0]; w[19:16] = m_ien[11:8]; end
        3'd4: begin w[7:0] = m_done[7:0]; w[15:8] = m_err[7:0]; w[31:16] = st[15:0]; end
        3'd6: begin w[3:0] = m_done[11:8]; w[11:8] = m_err[11:8]; w[23:16] = st[23:16]; end
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic logic [1:0] fixmode(input logic [1:0] v);
    return (v == 2'd3) ? 2'd0 : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) m_mode[c] = 2'd0;
      m_dir = '0; m_ien = '0; m_done = '0; m_err = '0;
      m_rdata = '0; m_irq = 1'b0;
    end else begin
      if (rd_en) m_rdata = mread(addr);
      if (wr_en && addr < 8'h20) begin
        case (addr[4:2])
          3'd0: for (int c = 0; c < 8; c++) begin
                  m_mode[c] = fixmode(wdata[4*c +: 2]); m_dir[c] = wdata[4*c+2];
                end
          3'd3: for (int c = 0; c < 4; c++) begin
                  m_mode[c+8] = fixmode(wdata[4*c +: 2]); m_dir[c+8] = wdata[4*c+2];
                end
          3'd2: m_ien = {wdata[19:16], wdata[7:0]};
          3'd4: begin m_done[7:0] &= ~wdata[7:0]; m_err[7:0] &= ~wdata[15:8]; end
          3'd6: begin m_done[11:8] &= ~wdata[3:0]; m_err[11:8] &= ~wdata[11:8]; end
          default: ;
        endcase
      end
      m_done |= ch_done;
      m_err  |= ch_err;
      m_irq = |(m_ien & (m_done | m_err));
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  bit live = 0;
  always @(negedge clk) begin
    if (live && !rst) begin
      logic [2*NCH-1:0] pm;
      for (int c = 0; c < NCH; c++) pm[2*c +: 2] = m_mode[c];
      check("R12 cycle rdata", rdata, m_rdata);
      check("R10 cycle irq", {31'b0, irq}, {31'b0, m_irq});
      check("R2 cycle ch_mode", {8'b0, ch_mode}, {8'b0, pm});
      check("R2 cycle ch_dir", {20'b0, ch_dir}, {20'b0, m_dir});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    ch_done = dn; ch_err = er;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 ch_mode", {8'b0, ch_mode}, 32'h0);
    rd(8'h10, 32'h0, "R1 status0");

    // R2 lower nibbles
    wr(8'h00, 32'h0000_0061);
    rd(8'h00, 32'h0000_0061, "R2 ctrl lo readback");
    check("R2 ch0 mode chain", {30'b0, ch_mode[1:0]}, 32'd1);
    check("R2 ch1 mode single", {30'b0, ch_mode[3:2]}, 32'd2);
    check("R2 ch1 dir", {31'b0, ch_dir[1]}, 32'd1);

    // R4 mode 3 maps to off
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h4444_4444, "R4 all-ones ctrl lo");

    // R3 upper nibbles
    wr(8'h0C, 32'hFFFF_2561);
    rd(8'h0C, 32'h0000_2561, "R3 ctrl hi readback");
    check("R3 ch11 mode", {30'b0, ch_mode[23:22]}, 32'd2);
    check("R3 ch9 dir", {31'b0, ch_dir[9]}, 32'd1);

    // R5 enables
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h000F_00FF, "R5 ien all");
    wr(8'h08, 32'h0002_0008);
    rd(8'h08, 32'h0002_0008, "R5 ien ch3 ch9");

    // R6 live state
    st = '0; st[1:0] = 2'd3; st[3:2] = 2'd1; st[15:14] = 2'd2;
    st[17:16] = 2'd2; st[23:22] = 2'd3;
    rd(8'h10, 32'h8007_0000, "R6 state lo");
    rd(8'h18, 32'h00C2_0000, "R6 state hi");
    st = '0;

    // R7 flags, R10 irq
    pulse(12'h008, 12'h000);
    check("R10 irq from ch3", {31'b0, irq}, 32'd1);
    rd(8'h10, 32'h0000_0008, "R7 done ch3");
    pulse(12'h020, 12'h200);
    rd(8'h18, 32'h0000_0200, "R7 err ch9");
    rd(8'h10, 32'h0000_0028, "R7 done ch3 ch5");

    // R8 write-back clears exactly those set
    wr(8'h10, 32'h0000_0028);
    rd(8'h10, 32'h0000_0000, "R8 write-back lo");
    check("R10 irq from ch9 err", {31'b0, irq}, 32'd1);
    wr(8'h18, 32'h0000_0000);
    rd(8'h18, 32'h0000_0200, "R8 zero write keeps");
    wr(8'h18, 32'h0000_0200);
    rd(8'h18, 32'h0000_0000, "R8 clear err ch9");
    check("R10 irq low", {31'b0, irq}, 32'd0);
    pulse(12'h020, 12'h000);
    check("R10 disabled ch5 no irq", {31'b0, irq}, 32'd0);
    wr(8'h10, 32'h0000_0020);

    // R9 set wins over clear
    pulse(12'h008, 12'h000);
    ch_done = 12'h008;
    wr(8'h10, 32'h0000_0008);
    ch_done = '0;
    rd(8'h10, 32'h0000_0008, "R9 set wins");
    wr(8'h10, 32'h0000_0008);

    // R11 reserved and aliasing offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0000_0000);
    wr(8'h28, 32'h0000_0000);
    wr(8'h2C, 32'h0000_0000);
    rd(8'h04, 32'h0, "R11 ctrl aux zero");
    rd(8'h14, 32'h0, "R11 status aux zero");
    rd(8'h1C, 32'h0, "R11 gap zero");
    rd(8'h20, 32'h0, "R11 above window zero");
    rd(8'h00, 32'h4444_4444, "R11 ctrl lo kept");
    rd(8'h08, 32'h0002_0008, "R11 ien kept");
    rd(8'h0C, 32'h0000_2561, "R11 ctrl hi kept");

    // R12 hold without rd_en
    addr = 8'h00;
    @(negedge clk);
    check("R12 hold", rdata, 32'h0000_2561);

    // mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int s;
      s = $urandom % 10;
      case (s)
        0: addr = 8'h00; 1: addr = 8'h04; 2: addr = 8'h08; 3: addr = 8'h0C;
        4: addr = 8'h10; 5: addr = 8'h14; 6: addr = 8'h18; 7: addr = 8'h1C;
        8: addr = 8'h20; default: addr = 8'h30;
      endcase
      wdata   = $urandom;
      wr_en   = ($urandom % 3) == 0;
      rd_en   = ($urandom % 2) == 0;
      ch_done = (($urandom % 4) == 0) ? NCH'($urandom) : '0;
      ch_err  = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      st      = (2*NCH)'($urandom);
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; ch_done = '0; ch_err = '0;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule